// File: doc/BRIEF.md
# SDLC Ring Repeater with Poll-Triggered Transmit

This block is the ring interface of a secondary station on a bit-serial SDLC loop. While loop operation is enabled, every bit arriving on the receive line goes back out on the transmit line one bit time later, so the station is a one-bit repeater on the ring. At the same time, an 8-bit window on the receive line looks for flags (01111110) and for the end-of-poll pattern (a 0 then seven 1s, 01111111). Both are written oldest bit first.

Software arms a go-active request. When an end-of-poll arrives with the request armed, the block changes the last 1 of that pattern to a 0 on the transmit line. The downstream stations therefore see a flag, and the block now holds the ring. It sends back-to-back flags until the local frame transmitter offers a byte on a valid/ready byte stream. It then serialises those bytes LSB first. After the data it sends a closing flag, and it keeps sending flags for as long as the request stays armed. When the request is gone and a byte slot opens with no data pending, the block returns to repeating. It cannot take the ring again until it has seen a flag followed by a new end-of-poll.

The byte stream is offered by the transmitter and accepted by the block. `tx_ready` is a single-clock pulse, one per byte slot, on the bit strobe that ends the current byte. A byte transfers only when `tx_valid` is high in that cycle. If the slot finds no valid byte, the block fills it with a flag. The transmitter must hold `tx_valid` and `tx_data` until the transfer. Zero insertion and CRC belong to the transmitter: the bytes are sent as given.

Top module: `sdlc_loop_rptr`

## Requirements
- R1: With `loop_en` low, `txd` is 1 and `sending` and `on_loop` are 0 from the next clock. Received patterns and an armed go-active request cause no transmission.
- R2: While repeating, the `txd` value set at a bit strobe equals the `rxd` value sampled at that strobe, which gives a one-bit delay on the line.
- R3: `on_loop` rises at the bit strobe that completes a flag 01111110 (oldest bit first) after loop operation is enabled. The block can take the ring only while `on_loop` is 1.
- R4: At the strobe that completes an end-of-poll 01111111, if the request is armed and a flag has been seen since enable or since the last release, `txd` is driven to 0 and `sending` rises at that same strobe.
- R5: An end-of-poll does not change the repeated bits if the request is not armed, or if no flag has been seen since enable or release.
- R6: Once the block holds the ring, each byte slot with no data offered carries a flag, sent LSB first as 0,1,1,1,1,1,1,0.
- R7: `tx_ready` pulses only while `sending` is high, on the bit strobe that ends a byte. The accepted byte's bit 0 is on `txd` from that strobe on, and the other bits follow LSB first on the next seven strobes.
- R8: If the request is cleared before any data byte, the flag in progress completes. At the next byte slot `sending` falls and repeating resumes.
- R9: After the last data byte, one closing flag is always sent. Further flags follow while the request is armed, and the block releases at the first empty slot after the request is clear.
- R10: After a release, an end-of-poll does not start a new transmission until a flag has been received. A flag followed by an end-of-poll, with the request armed, does start one.
- R11: Hardware reset and `chan_rst` clear the go-active request, `on_loop` and `sending`, and set `txd` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset |
| loop_en | input | 1 | Enables loop operation |
| go_wr | input | 1 | Write strobe for the go-active request |
| go_val | input | 1 | Value written to the go-active request |
| bit_en | input | 1 | One-clock strobe per line bit time |
| rxd | input | 1 | Serial receive line from the ring |
| txd | output | 1 | Serial transmit line to the ring |
| tx_data | input | 8 | Byte offered by the local transmitter |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte slot open; a transfer happens when valid |
| on_loop | output | 1 | Flag seen since enable; station synchronised |
| sending | output | 1 | Block is driving its own bits, not repeating |

## Verification
The bench feeds an armed end-of-poll before any flag, which catches a design that grabs the ring before it is synchronised. It also feeds an end-of-poll right after a release, which a design that forgets the lockout would seize. It checks the bit-exact takeover edge, where a design that forces the wrong bit sends a corrupted flag downstream. It clears the request part-way through a bridging flag, so a design that cuts the flag short shows up as an early repeat bit. It also checks that the closing flag comes out even with the request already clear, and that one byte is accepted exactly once with its bits LSB first. Channel reset is checked for clearing a stale request.

// File: rtl/sdlc_loop_pkg.sv
package sdlc_loop_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;  // 0111_1110, oldest bit in MSB
  localparam logic [BYTE_W-1:0] EOP_PAT  = 8'h7F;  // 0111_1111, oldest bit in MSB

  typedef enum logic [1:0] {
    LS_OFF    = 2'd0,
    LS_REPEAT = 2'd1,
    LS_SEND   = 2'd2
  } loop_st_e;
endpackage

// File: rtl/sdlc_pat_det.sv
module sdlc_pat_det
  import sdlc_loop_pkg::*;
#(
  parameter int PAT_W = BYTE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_en,
  input  logic rxd,
  output logic flag_hit,
  output logic eop_hit
);
  localparam int HIST_W = PAT_W - 1;

  logic [HIST_W-1:0] hist;
  logic [PAT_W-1:0]  window;

  // newest bit enters at the LSB, so the oldest bit sits in the MSB
  assign window   = {hist, rxd};
  assign flag_hit = bit_en && (window == PAT_W'(FLAG_PAT));
  assign eop_hit  = bit_en && (window == PAT_W'(EOP_PAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (clr) begin
      hist <= '0;
    end else if (bit_en) begin
      hist <= window[HIST_W-1:0];
    end
  end
endmodule

// File: rtl/sdlc_byte_ser.sv
module sdlc_byte_ser
  import sdlc_loop_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic [W-1:0] nxt_byte,
  output logic         at_bnd,
  output logic         next_bit
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic [W-1:0]  sh;
  logic [IW-1:0] idx;
  logic [IW-1:0] idx_nx;

  assign at_bnd   = (idx == LAST);
  assign idx_nx   = idx + IW'(1);
  // at a boundary the new byte's bit 0 goes out; otherwise the next bit, LSB first
  assign next_bit = at_bnd ? nxt_byte[0] : sh[idx_nx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= LAST;
    end else if (start) begin
      idx <= LAST;
    end else if (step) begin
      if (at_bnd) begin
        sh  <= nxt_byte;
        idx <= '0;
      end else begin
        idx <= idx_nx;
      end
    end
  end
endmodule

// File: rtl/sdlc_loop_ctrl.sv
module sdlc_loop_ctrl
  import sdlc_loop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chan_rst,
  input  logic     loop_en,
  input  logic     bit_en,
  input  logic     armed,
  input  logic     flag_hit,
  input  logic     eop_hit,
  input  logic     at_bnd,
  input  logic     tx_valid,
  output loop_st_e state,
  output logic     synced,
  output logic     take,
  output logic     release_now,
  output logic     pick_data
);
  logic elig;
  logic last_data;
  logic bnd;
  logic pick_flag;

  assign take        = (state == LS_REPEAT) && eop_hit && armed && elig;
  assign bnd         = (state == LS_SEND) && bit_en && at_bnd;
  assign pick_data   = bnd && tx_valid;
  assign pick_flag   = bnd && !tx_valid && (armed || last_data);
  assign release_now = bnd && !tx_valid && !armed && !last_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LS_OFF;
      synced    <= 1'b0;
      elig      <= 1'b0;
      last_data <= 1'b0;
    end else if (!loop_en || chan_rst) begin
      state     <= LS_OFF;
      synced    <= 1'b0;
      elig      <= 1'b0;
      last_data <= 1'b0;
    end else begin
      unique case (state)
        LS_OFF: state <= LS_REPEAT;
        LS_REPEAT: begin
          if (flag_hit) begin
            synced <= 1'b1;
            elig   <= 1'b1;
          end
          if (take) begin
            state     <= LS_SEND;
            last_data <= 1'b0;
          end
        end
        LS_SEND: begin
          if (pick_data) last_data <= 1'b1;
          if (pick_flag) last_data <= 1'b0;
          if (release_now) begin
            state     <= LS_REPEAT;
            elig      <= 1'b0;
            last_data <= 1'b0;
          end
        end
        default: state <= LS_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sdlc_loop_rptr.sv
module sdlc_loop_rptr
  import sdlc_loop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              loop_en,
  input  logic              go_wr,
  input  logic              go_val,
  input  logic              bit_en,
  input  logic              rxd,
  output logic              txd,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              on_loop,
  output logic              sending
);
  loop_st_e          state;
  logic              go_armed;
  logic              flag_hit;
  logic              eop_hit;
  logic              synced;
  logic              take;
  logic              release_now;
  logic              pick_data;
  logic              at_bnd;
  logic              ser_bit;
  logic              txd_q;
  logic              in_repeat;
  logic              det_clr;
  logic [BYTE_W-1:0] nxt_byte;

  assign det_clr   = !loop_en || chan_rst;
  assign in_repeat = (state == LS_REPEAT);
  assign nxt_byte  = pick_data ? tx_data : FLAG_PAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         go_armed <= 1'b0;
    else if (chan_rst)  go_armed <= 1'b0;
    else if (go_wr)     go_armed <= go_val;
  end

  sdlc_pat_det #(.PAT_W(BYTE_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (det_clr),
    .bit_en   (bit_en),
    .rxd      (rxd),
    .flag_hit (flag_hit),
    .eop_hit  (eop_hit)
  );

  sdlc_loop_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_rst    (chan_rst),
    .loop_en     (loop_en),
    .bit_en      (bit_en),
    .armed       (go_armed),
    .flag_hit    (flag_hit),
    .eop_hit     (eop_hit),
    .at_bnd      (at_bnd),
    .tx_valid    (tx_valid),
    .state       (state),
    .synced      (synced),
    .take        (take),
    .release_now (release_now),
    .pick_data   (pick_data)
  );

  sdlc_byte_ser #(.W(BYTE_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .step     (bit_en && (state == LS_SEND) && !release_now),
    .nxt_byte (nxt_byte),
    .at_bnd   (at_bnd),
    .next_bit (ser_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1;
    end else if (det_clr) begin
      txd_q <= 1'b1;
    end else if (bit_en) begin
      unique case (state)
        LS_REPEAT: txd_q <= take ? 1'b0 : rxd;
        LS_SEND:   txd_q <= release_now ? rxd : ser_bit;
        default:   txd_q <= 1'b1;
      endcase
    end
  end

  assign txd      = txd_q;
  assign tx_ready = (state == LS_SEND) && bit_en && at_bnd;
  assign on_loop  = synced;
  assign sending  = (state == LS_SEND);
endmodule

// File: rtl/sdlc_loop_rptr_chk.sv
module sdlc_loop_rptr_chk (
  input logic clk,
  input logic rst_n,
  input logic loop_en,
  input logic chan_rst,
  input logic bit_en,
  input logic rxd,
  input logic txd,
  input logic sending,
  input logic on_loop,
  input logic tx_ready,
  input logic armed,
  input logic eop_hit,
  input logic in_repeat
);
  AST_OFF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (txd && !sending && !on_loop)); // R1

  AST_REPEAT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && loop_en && !chan_rst && in_repeat && !eop_hit) |=> (txd == $past(rxd))); // R2

  AST_SEND_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sending |-> on_loop); // R3

  AST_TAKE_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> !txd); // R4

  AST_TAKE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> $past(armed && eop_hit && on_loop)); // R5

  AST_READY_IN_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (sending && bit_en)); // R7

  AST_CHAN_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!sending && !on_loop && txd)); // R11
endmodule

bind sdlc_loop_rptr sdlc_loop_rptr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loop_en   (loop_en),
  .chan_rst  (chan_rst),
  .bit_en    (bit_en),
  .rxd       (rxd),
  .txd       (txd),
  .sending   (sending),
  .on_loop   (on_loop),
  .tx_ready  (tx_ready),
  .armed     (go_armed),
  .eop_hit   (eop_hit),
  .in_repeat (in_repeat)
);

// File: tb/sdlc_loop_rptr_tb.sv
module sdlc_loop_rptr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_rst = 1'b0;
  logic       loop_en = 1'b0;
  logic       go_wr = 1'b0;
  logic       go_val = 1'b0;
  logic       bit_en = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       on_loop;
  logic       sending;

  int n_tests = 0;
  int n_fail  = 0;
  int n_acc   = 0;
  bit was_tick = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic  et;
    logic  es;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  sdlc_loop_rptr u_dut (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .loop_en(loop_en),
    .go_wr(go_wr), .go_val(go_val), .bit_en(bit_en), .rxd(rxd), .txd(txd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .on_loop(on_loop), .sending(sending)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor: compares after the edge that consumed a bit strobe
  always @(negedge clk) begin
    if (was_tick) begin
      if (sb_q.size() == 0) begin
        check("queue underrun", 1'b1, 1'b0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " txd"}, txd, e.et);
        check({e.tag, " sending"}, sending, e.es);
      end
    end
    if (bit_en && tx_ready && tx_valid) n_acc++;
    was_tick = bit_en;
  end

  task automatic tick(input logic r, input logic et, input logic es, input string tag);
    exp_t e;
    @(posedge clk); #2;
    rxd = r;
    bit_en = 1'b1;
    e.et = et; e.es = es; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #2;
    bit_en = 1'b0;
    @(posedge clk);
    @(posedge clk); #2;
  endtask

  task automatic rep(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) tick(bits[i], bits[i], 1'b0, tag);
  endtask

  task automatic sent_byte(input logic [7:0] b, input string tag);
    for (int i = 0; i < 8; i++) tick(1'b1, b[i], 1'b1, tag);
  endtask

  task automatic go_write(input logic v);
    @(posedge clk); #2;
    go_wr = 1'b1; go_val = v;
    @(posedge clk); #2;
    go_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    check("R11 reset txd", txd, 1'b1);
    check("R11 reset sending", sending, 1'b0);
    check("R11 reset on_loop", on_loop, 1'b0);
    check("R11 reset tx_ready", tx_ready, 1'b0);

    // R1: loop disabled, armed request, flag and end-of-poll on the line
    go_write(1'b1);
    for (int i = 14; i >= 0; i--) tick(15'b011111101111111 >> i, 1'b1, 1'b0, "R1");
    check("R1 on_loop off", on_loop, 1'b0);

    // enable; armed end-of-poll before any flag is ignored (R5)
    loop_en = 1'b1;
    repeat (2) @(posedge clk); #2;
    rep(16'h007F, 7, "R5 pre-flag");
    check("R3 no flag yet", on_loop, 1'b0);
    rep(16'h007E, 8, "R2");
    check("R3 on_loop after flag", on_loop, 1'b1);
    go_write(1'b0);
    rep(16'h007F, 7, "R5 unarmed");
    rep(16'h00B2, 8, "R2 mixed");

    // R4 takeover, R6 bridge flag, R7 data byte, R9 closing flag and release
    go_write(1'b1);
    rep(16'h007E, 8, "R2");
    rep(16'h003F, 6, "R2");
    tick(1'b1, 1'b0, 1'b1, "R4 takeover");
    sent_byte(8'h7E, "R6");
    tx_data = 8'hA5; tx_valid = 1'b1;
    tick(1'b1, 1'b1, 1'b1, "R7 bit0");
    tx_valid = 1'b0;
    for (int i = 1; i < 8; i++) begin
      tick(1'b1, tx_data[i], 1'b1, "R7 data");
      if (i == 2) go_write(1'b0);
    end
    check("R7 one transfer", n_acc == 1, 1'b1);
    sent_byte(8'h7E, "R9 closing flag");
    tick(1'b0, 1'b0, 1'b0, "R9 release");

    // R10: end-of-poll right after release is ignored, flag then end-of-poll is taken
    go_write(1'b1);
    rep(16'h007F, 7, "R10 lockout");
    check("R10 no send", sending, 1'b0);
    rep(16'h007E, 8, "R10");
    rep(16'h003F, 6, "R10");
    tick(1'b1, 1'b0, 1'b1, "R10 retake");

    // R6 flags while armed, R8 clear mid-flag, flag completes then release
    sent_byte(8'h7E, "R6 armed flags");
    for (int i = 0; i < 8; i++) begin
      if (i == 2) go_write(1'b0);
      tick(1'b1, FLAG_BIT(i), 1'b1, "R8 finish flag");
    end
    tick(1'b1, 1'b1, 1'b0, "R8 release");

    // R11: channel reset clears a stale request and sync
    go_write(1'b1);
    rep(16'h007E, 8, "R2");
    check("R3 resync", on_loop, 1'b1);
    @(posedge clk); #2 chan_rst = 1'b1;
    @(posedge clk); #2 chan_rst = 1'b0;
    check("R11 chan_rst on_loop", on_loop, 1'b0);
    check("R11 chan_rst txd", txd, 1'b1);
    repeat (2) @(posedge clk); #2;
    rep(16'h007E, 8, "R11");
    rep(16'h007F, 7, "R11 disarmed");
    check("R11 no send", sending, 1'b0);

    // R1: disable drops back to mark
    loop_en = 1'b0;
    repeat (2) @(posedge clk); #2;
    check("R1 disable txd", txd, 1'b1);
    check("R1 disable on_loop", on_loop, 1'b0);
    repeat (4) @(posedge clk); #2;
    check("scoreboard drained", sb_q.size() == 0, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic FLAG_BIT(input int i);
    logic [7:0] f = 8'h7E;
    return f[i];
  endfunction

  localparam logic [7:0] FLAG_PAT = 8'h7E;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule